// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block sits between a host bus and an embedded keyboard/mouse microcontroller. It is the shared register window that both sides use to pass bytes. The host sees two byte-wide ports, chosen by one address line. Address line low selects the data port and address line high selects the command/status port. The controller side has its own strobes. With them it can fill the output buffer, drain the input buffer, read the status byte, and set its own general-purpose status flags.

A single input buffer takes every host write. The address line used for the write is kept in a command flag, so the controller can tell commands from data. Two full flags track the buffers. The output-buffer flag drives a host interrupt, and the input-buffer flag drives an interrupt towards the controller. Each interrupt has its own enable input.

Host strobes are synchronous one-cycle qualifiers, sampled on the rising clock edge together with the chip select. Read data is combinational and valid while the read is held.

Top module: `kbc_host_bridge`

## Requirements
- R1: After reset, both buffers read 0x00, the status byte is 0x00, and both interrupt outputs are low.
- R2: While chip select and read are high, `host_dout` shows the output buffer when `host_a2`=0 and the status byte when `host_a2`=1. Otherwise it shows 0x00.
- R3: A selected host write with `host_a2`=0 loads the input buffer and clears the command flag (status bit 3) at the next edge.
- R4: A selected host write with `host_a2`=1 loads the input buffer and sets the command flag (status bit 3) at the next edge.
- R5: A controller output-buffer write sets status bit 0. A host data read clears it. When both happen in the same cycle, the bit stays set.
- R6: A host write sets status bit 1. A controller input-buffer read clears it. When both happen in the same cycle, the bit stays set.
- R7: `host_irq` is high exactly while status bit 0 is set and `host_irq_en` is high. It falls in the cycle after the host data read that empties the output buffer.
- R8: `ctl_ibf_irq` is high exactly while status bit 1 is set and `ctl_irq_en` is high.
- R9: A host write that arrives while status bit 1 is already set replaces the held byte, and bit 1 stays set.
- R10: A controller flag write stores `ctl_flags_din` into status bits 2, 4, 5, 6, 7, with bit 0 of the input going to status bit 2 and the rest going to bits 4 upward in order. Status bits 0, 1 and 3 are not affected.
- R11: Host strobes with chip select low have no effect. When read and write are high together, only the write is performed.
- R12: A host status read changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_a2 | input | 1 | Port select: 0 data, 1 command/status |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_irq | output | 1 | Output-buffer-full interrupt to the host |
| host_irq_en | input | 1 | Enable for host_irq |
| ctl_obuf_we | input | 1 | Controller writes the output buffer |
| ctl_obuf_din | input | 8 | Controller output byte |
| ctl_ibuf_rd | input | 1 | Controller consumes the input buffer |
| ctl_ibuf_dout | output | 8 | Input buffer contents |
| ctl_flags_we | input | 1 | Controller writes general-purpose status flags |
| ctl_flags_din | input | 5 | Flag values for status bits 2, 4, 5, 6, 7 |
| ctl_status | output | 8 | Status byte as seen by the controller |
| ctl_ibf_irq | output | 1 | Input-buffer-full interrupt to the controller |
| ctl_irq_en | input | 1 | Enable for ctl_ibf_irq |

## Verification
The bench targets the same-cycle collisions. These are a controller fill meeting a host drain, and a host write meeting a controller drain. A design that gave the clear priority would lose a byte notification and leave a full buffer that no one is told about. The bench overwrites a full input buffer with a command after a data byte. A design that kept the old byte, or kept the stale command flag, would hand the controller the wrong byte type. The bench also issues status reads, unselected strobes and flag writes with every bit set. These catch a status read that clears the output flag, a strobe decode that ignores chip select, and a flag write that leaks into the hardware-owned bits.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int F1_BIT  = 3;
  localparam int NUM_HW_FLAGS = 3;

  function automatic bit is_hw_flag(int i);
    return (i == OBF_BIT) || (i == IBF_BIT) || (i == F1_BIT);
  endfunction

  // Position of status bit i inside the packed general-purpose flag vector.
  function automatic int gp_slot(int i);
    int n;
    n = 0;
    for (int k = 0; k < i; k++) begin
      if (!is_hw_flag(k)) n++;
    end
    return n;
  endfunction

  typedef struct packed {
    logic rd_data;
    logic rd_stat;
    logic wr_data;
    logic wr_cmd;
  } host_op_t;

endpackage

// File: rtl/kbc_rst_sync.sv
module kbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_ni = sh_q[STAGES-1];
endmodule

// File: rtl/kbc_host_decode.sv
module kbc_host_decode
  import kbc_pkg::*;
(
  input  logic     cs,
  input  logic     rd,
  input  logic     wr,
  input  logic     a2,
  output host_op_t op
);
  logic wr_sel;
  logic rd_sel;

  always_comb begin
    wr_sel     = cs & wr;
    rd_sel     = cs & rd & ~wr;   // write takes priority over a colliding read
    op.wr_data = wr_sel & ~a2;
    op.wr_cmd  = wr_sel &  a2;
    op.rd_data = rd_sel & ~a2;
    op.rd_stat = rd_sel &  a2;
  end
endmodule

// File: rtl/kbc_buf.sv
module kbc_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          drain,
  output logic [DW-1:0] data,
  output logic          full
);
  logic [DW-1:0] data_q, data_d;
  logic          full_q, full_d;
  logic          data_en, full_en;

  always_comb begin
    data_en = load;
    data_d  = din;
    full_en = load | drain;
    full_d  = load;             // a fill in the same cycle beats a drain
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (data_en) data_q <= data_d;
      if (full_en) full_q <= full_d;
    end
  end

  assign data = data_q;
  assign full = full_q;

  a_r5_load_sets_full: assert property (@(posedge clk) disable iff (!rst_ni)
    load |=> full);
  a_r6_drain_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (drain && !load) |=> !full);
  a_r9_latest_byte: assert property (@(posedge clk) disable iff (!rst_ni)
    load |=> (data == $past(din)));
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    !load |=> $stable(data));
endmodule

// File: rtl/kbc_stat.sv
module kbc_stat
  import kbc_pkg::*;
#(
  parameter int DW  = 8,
  parameter int GPW = DW - NUM_HW_FLAGS
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           wr_data,
  input  logic           wr_cmd,
  input  logic           gp_we,
  input  logic [GPW-1:0] gp_din,
  input  logic           obf,
  input  logic           ibf,
  output logic [DW-1:0]  status
);
  logic f1_q, f1_d, f1_en;

  always_comb begin
    f1_en = wr_data | wr_cmd;
    f1_d  = wr_cmd;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    f1_q <= 1'b0;
    else if (f1_en) f1_q <= f1_d;
  end

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == OBF_BIT) begin : g_obf
      assign status[i] = obf;
    end else if (i == IBF_BIT) begin : g_ibf
      assign status[i] = ibf;
    end else if (i == F1_BIT) begin : g_f1
      assign status[i] = f1_q;
    end else begin : g_gp
      localparam int SLOT = gp_slot(i);
      logic q, d;
      always_comb d = gp_din[SLOT];
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)    q <= 1'b0;
        else if (gp_we) q <= d;
      end
      assign status[i] = q;
    end
  end

  a_r3_data_clears_f1: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_data |=> !status[F1_BIT]);
  a_r4_cmd_sets_f1: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_cmd |=> status[F1_BIT]);
  a_r10_f1_untouched: assert property (@(posedge clk) disable iff (!rst_ni)
    (gp_we && !wr_data && !wr_cmd) |=> $stable(status[F1_BIT]));
endmodule

// File: rtl/kbc_host_bridge.sv
module kbc_host_bridge
  import kbc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int GPW       = DW - NUM_HW_FLAGS,
  parameter int RST_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_cs,
  input  logic           host_rd,
  input  logic           host_wr,
  input  logic           host_a2,
  input  logic [DW-1:0]  host_din,
  output logic [DW-1:0]  host_dout,
  output logic           host_irq,
  input  logic           host_irq_en,
  input  logic           ctl_obuf_we,
  input  logic [DW-1:0]  ctl_obuf_din,
  input  logic           ctl_ibuf_rd,
  output logic [DW-1:0]  ctl_ibuf_dout,
  input  logic           ctl_flags_we,
  input  logic [GPW-1:0] ctl_flags_din,
  output logic [DW-1:0]  ctl_status,
  output logic           ctl_ibf_irq,
  input  logic           ctl_irq_en
);
  logic          rst_ni;
  host_op_t      op;
  logic [DW-1:0] obuf_data;
  logic          obf, ibf;
  logic [DW-1:0] status;

  kbc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni)
  );

  kbc_host_decode u_dec (
    .cs(host_cs), .rd(host_rd), .wr(host_wr), .a2(host_a2), .op(op)
  );

  // Controller to host
  kbc_buf #(.DW(DW)) u_obuf (
    .clk(clk), .rst_ni(rst_ni),
    .load(ctl_obuf_we), .din(ctl_obuf_din),
    .drain(op.rd_data),
    .data(obuf_data), .full(obf)
  );

  // Host to controller
  kbc_buf #(.DW(DW)) u_ibuf (
    .clk(clk), .rst_ni(rst_ni),
    .load(op.wr_data | op.wr_cmd), .din(host_din),
    .drain(ctl_ibuf_rd),
    .data(ctl_ibuf_dout), .full(ibf)
  );

  kbc_stat #(.DW(DW), .GPW(GPW)) u_stat (
    .clk(clk), .rst_ni(rst_ni),
    .wr_data(op.wr_data), .wr_cmd(op.wr_cmd),
    .gp_we(ctl_flags_we), .gp_din(ctl_flags_din),
    .obf(obf), .ibf(ibf),
    .status(status)
  );

  always_comb begin
    unique case (1'b1)
      op.rd_data: host_dout = obuf_data;
      op.rd_stat: host_dout = status;
      default:    host_dout = '0;
    endcase
  end

  assign host_irq    = obf & host_irq_en;
  assign ctl_ibf_irq = ibf & ctl_irq_en;
  assign ctl_status  = status;

  a_r7_irq_drops: assert property (@(posedge clk) disable iff (!rst_ni)
    (op.rd_data && !ctl_obuf_we) |=> !host_irq);
  a_r12_stat_read_keeps: assert property (@(posedge clk) disable iff (!rst_ni)
    (op.rd_stat && !ctl_obuf_we && !ctl_ibuf_rd && !ctl_flags_we) |=> $stable(ctl_status));
  a_r11_no_cs_no_load: assert property (@(posedge clk) disable iff (!rst_ni)
    !host_cs |=> $stable(ctl_ibuf_dout));
  a_r6_ibf_follows_write: assert property (@(posedge clk) disable iff (!rst_ni)
    (host_cs && host_wr) |=> ctl_status[IBF_BIT]);
endmodule

// File: tb/kbc_host_bridge_bench.sv
module kbc_host_bridge_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_cs, host_rd, host_wr, host_a2;
  logic [7:0] host_din, host_dout;
  logic       host_irq, host_irq_en;
  logic       ctl_obuf_we;
  logic [7:0] ctl_obuf_din, ctl_ibuf_dout, ctl_status;
  logic       ctl_ibuf_rd, ctl_flags_we, ctl_ibf_irq, ctl_irq_en;
  logic [4:0] ctl_flags_din;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  kbc_host_bridge u_kbc_host_bridge (.*);

  // Behavioural reference state
  int m_ib, m_ob, m_obf, m_ibf, m_f1, m_gp;

  function automatic int m_status();
    int s;
    s = m_obf | (m_ibf << 1) | (m_f1 << 3);
    s |= (m_gp & 1) << 2;
    s |= ((m_gp >> 1) & 15) << 4;
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ib = 0; m_ob = 0; m_obf = 0; m_ibf = 0; m_f1 = 0; m_gp = 0;
    end else begin
      bit wr, rd;
      wr = host_cs && host_wr;
      rd = host_cs && host_rd && !host_wr;
      if (rd && !host_a2) m_obf = 0;
      if (ctl_obuf_we) begin m_ob = ctl_obuf_din; m_obf = 1; end
      if (ctl_ibuf_rd) m_ibf = 0;
      if (wr) begin m_ib = host_din; m_ibf = 1; m_f1 = host_a2; end
      if (ctl_flags_we) m_gp = ctl_flags_din;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Continuous comparison against the model, mid-cycle
  always @(negedge clk) begin
    #3;
    if (rst_n && !finished) begin
      int exp_dout;
      exp_dout = 0;
      if (host_cs && host_rd && !host_wr) exp_dout = host_a2 ? m_status() : m_ob;
      chk("R2 host_dout", host_dout, exp_dout);
      chk("R10 ctl_status", ctl_status, m_status());
      chk("R9 ctl_ibuf_dout", ctl_ibuf_dout, m_ib);
      chk("R7 host_irq", host_irq, m_obf & host_irq_en);
      chk("R8 ctl_ibf_irq", ctl_ibf_irq, m_ibf & ctl_irq_en);
    end
  end

  task automatic idle();
    host_cs = 0; host_rd = 0; host_wr = 0; host_a2 = 0; host_din = 0;
    ctl_obuf_we = 0; ctl_obuf_din = 0; ctl_ibuf_rd = 0;
    ctl_flags_we = 0; ctl_flags_din = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic host_write(bit a2, logic [7:0] d, bit cs = 1);
    step(); host_cs = cs; host_wr = 1; host_a2 = a2; host_din = d;
  endtask

  task automatic host_read(bit a2, output logic [7:0] d);
    step(); host_cs = 1; host_rd = 1; host_a2 = a2;
    #2 d = host_dout;
  endtask

  task automatic settle();   // end current op, sample in the following cycle
    step(); #2;
  endtask

  logic [7:0] rv;

  initial begin
    idle();
    host_irq_en = 1; ctl_irq_en = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 status", ctl_status, 0);
    chk("R1 ibuf", ctl_ibuf_dout, 0);
    chk("R1 host_irq", host_irq, 0);
    chk("R1 ctl_ibf_irq", ctl_ibf_irq, 0);
    rst_n = 1;
    repeat (4) step();

    // Controller fills output buffer
    step(); ctl_obuf_we = 1; ctl_obuf_din = 8'hA5;
    settle();
    chk("R7 irq set", host_irq, 1);
    host_read(1, rv); chk("R5 obf in status", rv[0], 1);
    settle(); chk("R12 status read keeps obf", ctl_status[0], 1);
    host_irq_en = 0; #1 chk("R7 irq gated", host_irq, 0); host_irq_en = 1;
    host_read(0, rv); chk("R2 data read", rv, 8'hA5);
    settle();
    chk("R7 irq drops", host_irq, 0);
    chk("R5 obf cleared", ctl_status[0], 0);

    // Host data write then command overwrite
    host_write(0, 8'h11);
    settle();
    chk("R3 ibuf", ctl_ibuf_dout, 8'h11);
    chk("R3 f1 clear", ctl_status[3], 0);
    chk("R6 ibf set", ctl_status[1], 1);
    chk("R8 irq", ctl_ibf_irq, 1);
    host_write(1, 8'hD4);
    settle();
    chk("R9 overwrite", ctl_ibuf_dout, 8'hD4);
    chk("R9 ibf stays", ctl_status[1], 1);
    chk("R4 f1 set", ctl_status[3], 1);
    ctl_irq_en = 0; #1 chk("R8 gated", ctl_ibf_irq, 0); ctl_irq_en = 1;

    // Controller drains
    step(); ctl_ibuf_rd = 1;
    settle();
    chk("R6 ibf cleared", ctl_status[1], 0);
    chk("R8 irq low", ctl_ibf_irq, 0);

    // Flag write with every bit set
    step(); ctl_flags_we = 1; ctl_flags_din = 5'h1F;
    settle();
    chk("R10 flags", ctl_status, 8'hFC);

    // Unselected write
    host_write(0, 8'h77, 0);
    settle();
    chk("R11 no cs ibuf", ctl_ibuf_dout, 8'hD4);
    chk("R11 no cs status", ctl_status, 8'hFC);

    // Read and write together: write only
    step(); host_cs = 1; host_rd = 1; host_wr = 1; host_a2 = 0; host_din = 8'h3C;
    #2 chk("R11 collide no read", host_dout, 0);
    settle();
    chk("R11 collide write", ctl_ibuf_dout, 8'h3C);
    chk("R3 collide f1", ctl_status[3], 0);

    // Fill meets drain (output side)
    step(); ctl_obuf_we = 1; ctl_obuf_din = 8'h5A;
    step(); ctl_obuf_we = 1; ctl_obuf_din = 8'h66;
    host_cs = 1; host_rd = 1; host_a2 = 0;
    settle();
    chk("R5 fill beats drain", ctl_status[0], 1);
    host_read(0, rv); chk("R2 newest byte", rv, 8'h66);
    settle();

    // Fill meets drain (input side)
    step(); ctl_ibuf_rd = 1; host_cs = 1; host_wr = 1; host_a2 = 1; host_din = 8'h99;
    settle();
    chk("R6 write beats drain", ctl_status[1], 1);
    chk("R4 cmd byte", ctl_ibuf_dout, 8'h99);

    // Flag write of zero leaves hardware flags
    step(); ctl_flags_we = 1; ctl_flags_din = 5'h00;
    settle();
    chk("R10 flags clear", ctl_status, 8'h0A);

    repeat (4) step();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule